// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock of an I2C master from a fast input clock. While enabled, it first holds SCL high for the START hold time. It then alternates SCL low and high phases without end. The length of each phase is a programmed count plus a fixed number of internal cycles. The low phase counts from the cycle in which the block itself drives SCL low. One count pair (high, low) serves standard mode and a second pair serves fast mode. The `fast_sel` input chooses the pair, and its value is taken at the start of each phase.

A byte engine beside the block receives two strobes. `bit_strobe` marks the first cycle of every low phase, which is where SDA may change. `start_strobe` marks the end of the START hold. The four count registers have a small write port. A write takes effect only while `enable` is low. Dropping `enable` releases SCL high at once. Raising it again begins with a fresh START hold.

The control is a four-state machine:

- **OFF**: SCL released, counters at zero.
- **HOLD**: SCL high for the START hold.
- **LOW**: SCL driven low.
- **HIGH**: SCL high between bits.

The transitions are:

- **OFF to HOLD**: on enable.
- **HOLD to LOW**: hold elapsed; this transition also raises both strobes.
- **LOW to HIGH**: low elapsed.
- **HIGH to LOW**: high elapsed; raises `bit_strobe`.
- **any state to OFF**: when enable is low.

Top module: `scl_period_gen`

## Requirements
- R1: While `enable` is sampled low at a clock edge, the cycle after that edge has `scl_out`=1, `bit_strobe`=0 and `start_strobe`=0; this is also the state out of reset.
- R2: When `enable` is first sampled high at edge e, `scl_out` stays 1 for HCNT+3 cycles after e and falls at edge e+HCNT+3, where HCNT is the selected high count.
- R3: Every low phase lasts LCNT+1 cycles, where LCNT is the selected low count; an LCNT of 0 gives a one-cycle low.
- R4: Every high phase that follows a low phase lasts HCNT+8 cycles.
- R5: A write with `wr_en`=1 stores `wr_data` only if `enable` is sampled low at that edge; a write made while enabled changes nothing. The address map is: 0 standard high, 1 standard low, 2 fast high, 3 fast low.
- R6: `bit_strobe` is 1 exactly in the first cycle of each low phase. `start_strobe` is 1 only in the first low cycle after the START hold, together with `bit_strobe`.
- R7: `fast_sel`=0 selects the standard pair and `fast_sel`=1 selects the fast pair. The value is sampled at the edge on which each phase begins, so a change affects the next phase only.
- R8: Out of reset, the counts are: standard high 20, standard low 27, fast high 3, fast low 9.
- R9: Dropping `enable` in mid-phase releases SCL in the next cycle. The next enable restarts from the START hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock that the periods are counted in |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Controller enable; low stops the clock and unlocks the registers |
| fast_sel | input | 1 | 0 selects the standard count pair, 1 selects the fast pair |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 std high, 1 std low, 2 fast high, 3 fast low |
| wr_data | input | CNT_W | Count value to store |
| scl_out | output | 1 | SCL level: 1 released high, 0 driven low |
| bit_strobe | output | 1 | One-cycle pulse in the first cycle of every low phase |
| start_strobe | output | 1 | One-cycle pulse when the START hold has elapsed |

## Verification
The assertions assume that `rst_n` is released synchronously with respect to the inputs. They also assume that every input changes only between clock edges. The low-width property relies on the counts staying fixed while the block runs, which holds because writes are locked while `enable` is high. The stimulus keeps to these assumptions by driving every input on the falling clock edge. It also switches `fast_sel` mid-run only as a plain level, so the phase-start sampling rule decides which pair applies. Writes made while the block is enabled are issued on purpose, to show that the lock holds.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_HOLD = 2'd1,
        PH_LOW  = 2'd2,
        PH_HIGH = 2'd3
    } scl_phase_e;

    localparam int NUM_CNT_REGS = 4;
    localparam logic [1:0] ADDR_STD_HIGH  = 2'd0;
    localparam logic [1:0] ADDR_STD_LOW   = 2'd1;
    localparam logic [1:0] ADDR_FAST_HIGH = 2'd2;
    localparam logic [1:0] ADDR_FAST_LOW  = 2'd3;

    localparam int HOLD_EXTRA = 3;
    localparam int HIGH_EXTRA = 8;
    localparam int LOW_EXTRA  = 1;

endpackage

// File: rtl/scl_count_regs.sv
module scl_count_regs #(
    parameter int              CNT_W          = 16,
    parameter logic [CNT_W-1:0] DEF_STD_HIGH  = 20,
    parameter logic [CNT_W-1:0] DEF_STD_LOW   = 27,
    parameter logic [CNT_W-1:0] DEF_FAST_HIGH = 3,
    parameter logic [CNT_W-1:0] DEF_FAST_LOW  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] std_high,
    output logic [CNT_W-1:0] std_low,
    output logic [CNT_W-1:0] fast_high,
    output logic [CNT_W-1:0] fast_low
);
    import scl_gen_pkg::*;

    localparam logic [CNT_W-1:0] DEFS [NUM_CNT_REGS] =
        '{DEF_STD_HIGH, DEF_STD_LOW, DEF_FAST_HIGH, DEF_FAST_LOW};

    logic [CNT_W-1:0] bank [NUM_CNT_REGS];
    logic             wr_ok;

    // Writes are locked while the controller runs
    assign wr_ok = wr_en && !enable;

    for (genvar i = 0; i < NUM_CNT_REGS; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bank[i] <= DEFS[i];
            else if (wr_ok && (wr_addr == 2'(i)))
                bank[i] <= wr_data;
        end
    end

    assign std_high  = bank[ADDR_STD_HIGH];
    assign std_low   = bank[ADDR_STD_LOW];
    assign fast_high = bank[ADDR_FAST_HIGH];
    assign fast_low  = bank[ADDR_FAST_LOW];

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fast_sel,
    input  logic [CNT_W-1:0] std_high,
    input  logic [CNT_W-1:0] std_low,
    input  logic [CNT_W-1:0] fast_high,
    input  logic [CNT_W-1:0] fast_low,
    output logic             scl_out,
    output logic             bit_strobe,
    output logic             start_strobe
);
    import scl_gen_pkg::*;

    localparam int TW = CNT_W + 4;

    scl_phase_e       state_q, state_d;
    logic [TW-1:0]    cnt_q, cnt_d, limit_q, limit_d;
    logic             fall_q, fall_d, start_q, start_d;
    logic [TW-1:0]    high_sel, low_sel;
    logic [TW-1:0]    hold_lim, high_lim, low_lim;
    logic             phase_end;

    assign high_sel  = TW'(fast_sel ? fast_high : std_high);
    assign low_sel   = TW'(fast_sel ? fast_low  : std_low);
    assign hold_lim  = high_sel + TW'(HOLD_EXTRA - 1);
    assign high_lim  = high_sel + TW'(HIGH_EXTRA - 1);
    assign low_lim   = low_sel  + TW'(LOW_EXTRA - 1);
    assign phase_end = (cnt_q == limit_q);

    // Next state and phase counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + TW'(1);
        limit_d = limit_q;
        fall_d  = 1'b0;
        start_d = 1'b0;
        if (!enable) begin
            state_d = PH_OFF;
            cnt_d   = '0;
            limit_d = '0;
        end else begin
            unique case (state_q)
                PH_OFF: begin
                    state_d = PH_HOLD;
                    cnt_d   = '0;
                    limit_d = hold_lim;
                end
                PH_HOLD: begin
                    if (phase_end) begin
                        state_d = PH_LOW;
                        cnt_d   = '0;
                        limit_d = low_lim;
                        fall_d  = 1'b1;
                        start_d = 1'b1;
                    end
                end
                PH_LOW: begin
                    if (phase_end) begin
                        state_d = PH_HIGH;
                        cnt_d   = '0;
                        limit_d = high_lim;
                    end
                end
                PH_HIGH: begin
                    if (phase_end) begin
                        state_d = PH_LOW;
                        cnt_d   = '0;
                        limit_d = low_lim;
                        fall_d  = 1'b1;
                    end
                end
                default: begin
                    state_d = PH_OFF;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_OFF;
            cnt_q   <= '0;
            limit_q <= '0;
            fall_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            limit_q <= limit_d;
            fall_q  <= fall_d;
            start_q <= start_d;
        end
    end

    // Outputs
    always_comb begin
        scl_out      = (state_q != PH_LOW);
        bit_strobe   = fall_q;
        start_strobe = start_q;
    end

endmodule

// File: rtl/scl_period_gen.sv
module scl_period_gen #(
    parameter int               CNT_W         = 16,
    parameter logic [CNT_W-1:0] DEF_STD_HIGH  = 20,
    parameter logic [CNT_W-1:0] DEF_STD_LOW   = 27,
    parameter logic [CNT_W-1:0] DEF_FAST_HIGH = 3,
    parameter logic [CNT_W-1:0] DEF_FAST_LOW  = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             fast_sel,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic             scl_out,
    output logic             bit_strobe,
    output logic             start_strobe
);
    logic [CNT_W-1:0] std_high, std_low, fast_high, fast_low;

    scl_count_regs #(
        .CNT_W(CNT_W), .DEF_STD_HIGH(DEF_STD_HIGH), .DEF_STD_LOW(DEF_STD_LOW),
        .DEF_FAST_HIGH(DEF_FAST_HIGH), .DEF_FAST_LOW(DEF_FAST_LOW)
    ) i_regs (
        .clk(clk), .rst_n(rst_n), .enable(enable), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .std_high(std_high), .std_low(std_low),
        .fast_high(fast_high), .fast_low(fast_low)
    );

    scl_phase_fsm #(.CNT_W(CNT_W)) i_fsm (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
        .std_high(std_high), .std_low(std_low),
        .fast_high(fast_high), .fast_low(fast_low),
        .scl_out(scl_out), .bit_strobe(bit_strobe), .start_strobe(start_strobe)
    );

endmodule

// File: rtl/scl_period_gen_chk.sv
module scl_period_gen_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             fast_sel,
    input logic             scl_out,
    input logic             bit_strobe,
    input logic             start_strobe,
    input logic [CNT_W-1:0] std_high,
    input logic [CNT_W-1:0] std_low,
    input logic [CNT_W-1:0] fast_high,
    input logic [CNT_W-1:0] fast_low
);
    logic             scl_q, fast_q;
    logic [CNT_W:0]   low_run, low_exp;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q   <= 1'b1;
            fast_q  <= 1'b0;
            low_run <= '0;
            low_exp <= '0;
        end else begin
            scl_q   <= scl_out;
            fast_q  <= fast_sel;
            low_run <= scl_out ? '0 : low_run + 1'b1;
            if (scl_q && !scl_out)
                low_exp <= (CNT_W+1)'(fast_q ? fast_low : std_low) + 1'b1;
        end
    end

    assert_released_when_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_out && !bit_strobe && !start_strobe));

    assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(scl_out) && $past(enable)) |-> (low_run == low_exp));

    assert_regs_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> $stable({std_high, std_low, fast_high, fast_low}));

    assert_strobe_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bit_strobe |-> $fell(scl_out));

    assert_fall_has_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_out) |-> bit_strobe);

    assert_start_with_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start_strobe |-> bit_strobe);

endmodule

bind scl_period_gen scl_period_gen_chk #(.CNT_W(CNT_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
    .scl_out(scl_out), .bit_strobe(bit_strobe), .start_strobe(start_strobe),
    .std_high(std_high), .std_low(std_low),
    .fast_high(fast_high), .fast_low(fast_low)
);

// File: tb/test_scl_period_gen.sv
`timescale 1ns/1ps
module test_scl_period_gen;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         enable = 1'b0;
    logic         fast_sel = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = 2'd0;
    logic [W-1:0] wr_data = '0;
    logic         scl_out, bit_strobe, start_strobe;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    scl_period_gen i_scl_period_gen (
        .clk(clk), .rst_n(rst_n), .enable(enable), .fast_sel(fast_sel),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .scl_out(scl_out), .bit_strobe(bit_strobe), .start_strobe(start_strobe)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: phase number and cycles left in it
    int m_reg [4];
    int m_ph;      // 0 off, 1 start hold, 2 low, 3 high
    int m_left;
    bit m_bs, m_ss;

    function automatic int sel_h();
        return fast_sel ? m_reg[2] : m_reg[0];
    endfunction
    function automatic int sel_l();
        return fast_sel ? m_reg[3] : m_reg[1];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_reg[0] = 20; m_reg[1] = 27; m_reg[2] = 3; m_reg[3] = 9;
            m_ph = 0; m_left = 0; m_bs = 0; m_ss = 0;
        end else begin
            m_bs = 0; m_ss = 0;
            if (!enable) begin
                m_ph = 0; m_left = 0;
                if (wr_en) m_reg[wr_addr] = int'(wr_data);
            end else if (m_ph == 0) begin
                m_ph = 1; m_left = sel_h() + 3;
            end else begin
                m_left = m_left - 1;
                if (m_left == 0) begin
                    if (m_ph == 2) begin
                        m_ph = 3; m_left = sel_h() + 8;
                    end else begin
                        m_ss = (m_ph == 1);
                        m_bs = 1;
                        m_ph = 2; m_left = sel_l() + 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(scl_out == (m_ph != 2),
                  m_ph == 0 ? "R1 scl" : m_ph == 1 ? "R2 scl" : m_ph == 2 ? "R3 scl" : "R4 scl",
                  scl_out, m_ph != 2);
            check(bit_strobe == m_bs, "R6 bit_strobe", bit_strobe, m_bs);
            check(start_strobe == m_ss, "R6 start_strobe", start_strobe, m_ss);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_reg(input logic [1:0] a, input int v);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = W'(v);
        @(negedge clk);
        wr_en = 0;
    endtask

    // Raise enable and count high cycles until the first fall
    task automatic start_and_hold(input string tag, input int exp);
        int n;
        @(negedge clk);
        enable = 1;
        n = 0;
        @(negedge clk);
        while (scl_out) begin n++; @(negedge clk); end
        check(n == exp, tag, n, exp);
        check(start_strobe == 1'b1, "R6 start pulse after hold", start_strobe, 1);
    endtask

    // Measure the next full low phase and the high phase after it
    task automatic measure(input string tag, input int exp_low, input int exp_high);
        int nl, nh;
        while (!scl_out) @(negedge clk);
        while (scl_out) @(negedge clk);
        nl = 0;
        while (!scl_out) begin nl++; @(negedge clk); end
        nh = 0;
        while (scl_out) begin nh++; @(negedge clk); end
        check(nl == exp_low, {tag, " low"}, nl, exp_low);
        check(nh == exp_high, {tag, " high"}, nh, exp_high);
    endtask

    initial begin
        idle(3);
        check(scl_out == 1 && !bit_strobe && !start_strobe, "R1 reset state", scl_out, 1);
        rst_n = 1;
        idle(4);
        check(scl_out == 1, "R1 disabled after reset", scl_out, 1);

        // Defaults, standard mode
        start_and_hold("R2 hold std default", 23);
        measure("R8 std default", 28, 28);
        measure("R3 R4 std default repeat", 28, 28);

        // Fast defaults
        @(negedge clk); enable = 0;
        @(negedge clk);
        check(scl_out == 1 && !bit_strobe, "R1 release on disable", scl_out, 1);
        fast_sel = 1;
        start_and_hold("R2 hold fast default", 6);
        measure("R7 fast default", 10, 11);

        // Program new counts while disabled, boundary LCNT=0
        @(negedge clk); enable = 0;
        write_reg(2'd0, 5);
        write_reg(2'd1, 2);
        write_reg(2'd2, 1);
        write_reg(2'd3, 0);
        start_and_hold("R2 hold fast programmed", 4);
        measure("R3 fast lcnt zero", 1, 9);

        // Speed switch while running applies from the next phase
        @(negedge clk); fast_sel = 0;
        measure("R7 switch to std", 3, 13);

        // Write while enabled is ignored
        write_reg(2'd1, 9);
        measure("R5 write while enabled ignored", 3, 13);
        @(negedge clk); enable = 0;
        write_reg(2'd1, 9);
        start_and_hold("R5 hold after unlocked write", 8);
        measure("R5 write while disabled taken", 10, 13);

        // Disable in mid low phase
        while (scl_out) @(negedge clk);
        @(negedge clk);
        enable = 0;
        @(negedge clk);
        check(scl_out == 1 && !bit_strobe, "R9 release mid phase", scl_out, 1);
        idle(3);
        start_and_hold("R9 restart with hold", 8);
        measure("R9 periods after restart", 10, 13);

        // Disable in mid high phase
        while (scl_out) @(negedge clk);
        while (!scl_out) @(negedge clk);
        idle(2);
        enable = 0;
        @(negedge clk);
        check(scl_out == 1 && !start_strobe, "R9 disable during high", scl_out, 1);
        idle(5);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule